// File: doc/BRIEF.md
# Dual-mixer phase tag generator

This block measures the phase of several fast input clocks against one slightly slower offset clock. It mixes them digitally and timestamps the result. Each fast input is treated as data and captured on every rising edge of the offset clock, with no analogue filtering. The captured sequence is a slow beat waveform whose period equals the beat period of the two clock frequencies. For example, a 62.5 MHz input sampled at 62.496185 MHz gives a beat of about 3.814 kHz. A beat period of 2^14 offset cycles therefore maps one full input period onto a 14-bit count.

Near each beat transition the captured waveform chatters. A per-channel deglitcher accepts a rising transition only after a programmable run of consecutive high samples. It accepts the next one only after an equally long run of low samples. Every accepted rising edge is stamped with a free-running counter clocked by the offset clock. The stamp is corrected back to the capture of the first high sample of the run. It is then presented as a one-cycle valid pulse with a tag value, one channel per input. A control loop downstream compares tags between channels, or between successive tags of one channel.

Top module: `ddmtd_phase_tagger`

## Requirements
- R1: While `rst` is high on a rising edge of `clk_ofs`, all `tag_valid` bits are low on the following cycle. The tag counter holds 0 at the first edge after `rst` is released, and that edge is edge index 0.
- R2: Each `clk_in` bit is captured on every rising edge of `clk_ofs`. Captures from edge index 0 onward are the only samples the deglitcher acts on.
- R3: A channel that is armed declares a rising edge when it has captured `glitch_len` consecutive high samples. The `tag_valid` bit of that channel is high during the cycle that follows edge index k+2, where k is the capture edge of the last of those high samples.
- R4: The tag value equals the edge index of the first high sample of the qualifying run, modulo 2^14. It wraps from 16383 to 0.
- R5: After reset and after every declared edge, a channel is disarmed. It re-arms only after `glitch_len` consecutive low samples. A high sample while disarmed restarts that low count, so a stream that starts high, or a short high glitch, produces no tag.
- R6: A run of fewer than `glitch_len` high samples in an armed channel produces no tag. It does not shorten the run needed afterwards, because any low sample restarts the count.
- R7: `tag_valid` is a single-cycle pulse, and exactly one tag is produced per qualified rising edge.
- R8: When `chan_en` of a channel is low at the edge that would assert its pulse, no pulse is produced. The deglitcher still follows the input, so the channel disarms as usual.
- R9: Channels are independent. Activity, enable or glitches on one channel do not change the tags of another.
- R10: A `glitch_len` value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ofs | input | 1 | Offset sampling clock; every register runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_in | input | NCH | Fast input clocks, sampled as data |
| glitch_len | input | LEN_W | Required run length of equal samples (0 treated as 1) |
| chan_en | input | NCH | Per-channel tag enable |
| tag_valid | output | NCH | One-cycle pulse per accepted rising beat edge |
| tag_value | output | NCH*TAG_W | Tag of channel c in bits [c*TAG_W +: TAG_W] |

## Verification
A tag is due two `clk_ofs` edges after the edge that captures the last high sample of a qualifying run. That delay comes from the two capture stages in front of the deglitcher, and the pulse is then registered. The bench samples the inputs itself on each rising edge and runs its own run-length model. It queues each expected tag together with the edge index at which the pulse must be visible. A monitor on the falling edge requires the pulse in exactly that cycle with exactly that value. It flags early, late, extra and missing pulses alike. Directed patterns with short glitches cover arming, masking, wrap-free stamps and the zero-length setting. Two behavioural clocks with a 127-cycle beat exercise continuous operation across several counter wraps.

// File: rtl/ddmtd_pkg.sv
`timescale 1ps/1ps
package ddmtd_pkg;

  // Deglitcher state: waiting for a low run (disarmed) or a high run (armed)
  typedef enum logic {
    DG_WAIT_LOW  = 1'b0,
    DG_WAIT_HIGH = 1'b1
  } dg_state_e;

  localparam int unsigned DEF_TAG_W       = 14;
  localparam int unsigned DEF_LEN_W       = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/ddmtd_sampler.sv
`timescale 1ps/1ps
module ddmtd_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic smp,
  output logic smp_vld
);

  logic [STAGES-1:0] cap_q;
  logic [STAGES-1:0] vld_q;

  // First stage is the mixing flop; the rest settle metastability
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      vld_q <= '0;
    end else begin
      cap_q <= {cap_q[STAGES-2:0], raw};
      vld_q <= {vld_q[STAGES-2:0], 1'b1};
    end
  end

  assign smp     = cap_q[STAGES-1];
  assign smp_vld = vld_q[STAGES-1];

  AST_SMP_DELAYED: assert property (@(posedge clk) disable iff (rst)
    smp_vld |-> (smp == $past(raw, STAGES))) else $error("sampler delay"); // R2

endmodule

// File: rtl/ddmtd_tag_counter.sv
`timescale 1ps/1ps
module ddmtd_tag_counter #(
  parameter int unsigned TAG_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  output logic [TAG_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt == $past(cnt) + 1'b1)) else $error("counter step"); // R4

endmodule

// File: rtl/ddmtd_deglitch.sv
`timescale 1ps/1ps
module ddmtd_deglitch
  import ddmtd_pkg::*;
#(
  parameter int unsigned LEN_W       = 4,
  parameter int unsigned TAG_W       = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp,
  input  logic             smp_vld,
  input  logic [LEN_W-1:0] len,
  input  logic             en,
  input  logic [TAG_W-1:0] cnt,
  output logic             tag_vld,
  output logic [TAG_W-1:0] tag
);

  // Counter runs SYNC_STAGES edges ahead of the sample in use; one more
  // is absorbed because the run's first sample is len-1 samples back.
  localparam logic [TAG_W-1:0] LAT_ADJ = TAG_W'(SYNC_STAGES - 1);

  dg_state_e        state_q;
  logic [LEN_W-1:0] run_q;
  logic [LEN_W-1:0] n_eff;
  logic             match;
  logic             run_done;

  always_comb begin
    n_eff    = (len == '0) ? LEN_W'(1) : len;
    match    = smp_vld && (smp == (state_q == DG_WAIT_HIGH));
    run_done = ({1'b0, run_q} + 1'b1) == {1'b0, n_eff};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DG_WAIT_LOW;
      run_q   <= '0;
      tag_vld <= 1'b0;
      tag     <= '0;
    end else begin
      tag_vld <= 1'b0;
      if (smp_vld) begin
        if (!match) begin
          run_q <= '0;
        end else if (!run_done) begin
          run_q <= run_q + 1'b1;
        end else begin
          run_q <= '0;
          if (state_q == DG_WAIT_HIGH) begin
            state_q <= DG_WAIT_LOW;
            tag_vld <= en;
            tag     <= cnt - TAG_W'(n_eff) - LAT_ADJ;
          end else begin
            state_q <= DG_WAIT_HIGH;
          end
        end
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tag_vld |=> !tag_vld) else $error("pulse wider than one cycle"); // R7
  AST_EDGE_FROM_HIGH: assert property (@(posedge clk) disable iff (rst)
    tag_vld |-> ($past(smp) && $past(smp_vld))) else $error("tag without high sample"); // R3
  AST_DISARM_AFTER_TAG: assert property (@(posedge clk) disable iff (rst)
    tag_vld |-> (state_q == DG_WAIT_LOW)) else $error("still armed after tag"); // R5
  AST_MASKED_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    tag_vld |-> $past(en)) else $error("tag while disabled"); // R8
  AST_RUN_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
    run_q < n_eff) else $error("run counter overflow"); // R6

endmodule

// File: rtl/ddmtd_phase_tagger.sv
`timescale 1ps/1ps
module ddmtd_phase_tagger #(
  parameter int unsigned NCH         = 2,
  parameter int unsigned TAG_W       = ddmtd_pkg::DEF_TAG_W,
  parameter int unsigned LEN_W       = ddmtd_pkg::DEF_LEN_W,
  parameter int unsigned SYNC_STAGES = ddmtd_pkg::DEF_SYNC_STAGES
) (
  input  logic                 clk_ofs,
  input  logic                 rst,
  input  logic [NCH-1:0]       clk_in,
  input  logic [LEN_W-1:0]     glitch_len,
  input  logic [NCH-1:0]       chan_en,
  output logic [NCH-1:0]       tag_valid,
  output logic [NCH*TAG_W-1:0] tag_value
);

  logic [TAG_W-1:0] stamp;

  ddmtd_tag_counter #(.TAG_W(TAG_W)) u_cnt (
    .clk (clk_ofs),
    .rst (rst),
    .cnt (stamp)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic smp;
    logic smp_vld;

    ddmtd_sampler #(.STAGES(SYNC_STAGES)) u_smp (
      .clk     (clk_ofs),
      .rst     (rst),
      .raw     (clk_in[c]),
      .smp     (smp),
      .smp_vld (smp_vld)
    );

    ddmtd_deglitch #(
      .LEN_W       (LEN_W),
      .TAG_W       (TAG_W),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_dg (
      .clk     (clk_ofs),
      .rst     (rst),
      .smp     (smp),
      .smp_vld (smp_vld),
      .len     (glitch_len),
      .en      (chan_en[c]),
      .cnt     (stamp),
      .tag_vld (tag_valid[c]),
      .tag     (tag_value[c*TAG_W +: TAG_W])
    );
  end

endmodule

// File: tb/ddmtd_phase_tagger_bench.sv
`timescale 1ps/1ps
module ddmtd_phase_tagger_bench;

  localparam int CLK_PERIOD = 16384;          // offset clock, ps
  localparam int IN_HALF    = 8128;           // input clock half period, ps
  localparam int TAG_W      = 14;
  localparam int LEN_W      = 4;

  logic             clk_ofs = 1'b0;
  logic             rst     = 1'b1;
  logic [1:0]       pat     = 2'b00;
  logic [1:0]       ideal   = 2'b00;
  logic             use_ideal = 1'b0;
  logic [1:0]       clk_in;
  logic [LEN_W-1:0] glitch_len = 4'd4;
  logic [1:0]       chan_en = 2'b11;
  logic [1:0]       tag_valid;
  logic [2*TAG_W-1:0] tag_value;

  int n_chk  = 0;
  int n_fail = 0;

  assign clk_in = use_ideal ? ideal : pat;

  always #(CLK_PERIOD/2) clk_ofs = ~clk_ofs;

  // Behavioural input clocks: beat of 127 offset cycles, edges never on clk_ofs edges
  initial begin #1;    forever begin ideal[0] = ~ideal[0]; #IN_HALF; end end
  initial begin #4001; forever begin ideal[1] = ~ideal[1]; #IN_HALF; end end

  ddmtd_phase_tagger #(.NCH(2), .TAG_W(TAG_W), .LEN_W(LEN_W), .SYNC_STAGES(2)) u_ddmtd_phase_tagger (
    .clk_ofs    (clk_ofs),
    .rst        (rst),
    .clk_in     (clk_in),
    .glitch_len (glitch_len),
    .chan_en    (chan_en),
    .tag_valid  (tag_valid),
    .tag_value  (tag_value)
  );

  // Scoreboard items: {due edge index, 2'b0, tag}
  logic [47:0] q0[$];
  logic [47:0] q1[$];

  task automatic push_exp(input int ch, input int due, input int tagv);
    logic [47:0] it;
    it = {due[31:0], 2'b00, tagv[TAG_W-1:0]};
    if (ch == 0) q0.push_back(it); else q1.push_back(it);
  endtask

  // Predictor: samples the inputs as the flop does and applies the run rules
  int k = 0;
  int last_k = -1;
  bit m_armed[2];
  int m_run[2];

  always @(posedge clk_ofs) begin
    if (rst) begin
      k = 0; last_k = -1;
      for (int c = 0; c < 2; c++) begin m_armed[c] = 1'b0; m_run[c] = 0; end
      q0.delete(); q1.delete();
    end else begin
      for (int c = 0; c < 2; c++) begin
        int neff;
        neff = (glitch_len == 0) ? 1 : int'(glitch_len);       // R10
        if (clk_in[c] == m_armed[c]) begin
          if (m_run[c] + 1 == neff) begin
            m_run[c] = 0;
            if (m_armed[c] && chan_en[c])                     // R8
              push_exp(c, k + 2, (k - (neff - 1)) & 16'h3FFF); // R3 R4
            m_armed[c] = !m_armed[c];                         // R5
          end else m_run[c] = m_run[c] + 1;
        end else m_run[c] = 0;                                // R6
      end
      last_k = k;
      k = k + 1;
    end
  end

  // Monitor
  always @(negedge clk_ofs) begin
    if (rst) begin
      if (last_k == -1 && $time > 0) begin
        n_chk++;
        if (tag_valid !== 2'b00) begin
          n_fail++;
          $display("FAIL R1 valid in reset act=%b exp=00", tag_valid);
        end
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic [47:0] fr;
        bit have;
        have = (c == 0) ? (q0.size() > 0) : (q1.size() > 0);
        fr = '0;
        if (have) fr = (c == 0) ? q0[0] : q1[0];
        if (tag_valid[c]) begin
          n_chk++;
          if (!have) begin
            n_fail++;
            $display("FAIL R6 R8 R9 ch%0d unexpected tag act=%0d exp=none at edge %0d",
                     c, tag_value[c*TAG_W +: TAG_W], last_k);
          end else begin
            if (c == 0) void'(q0.pop_front()); else void'(q1.pop_front());
            if (int'(fr[47:16]) != last_k) begin
              n_fail++;
              $display("FAIL R3 ch%0d pulse edge act=%0d exp=%0d", c, last_k, int'(fr[47:16]));
            end else if (tag_value[c*TAG_W +: TAG_W] !== fr[TAG_W-1:0]) begin
              n_fail++;
              $display("FAIL R4 ch%0d tag act=%0d exp=%0d", c,
                       tag_value[c*TAG_W +: TAG_W], fr[TAG_W-1:0]);
            end
          end
        end else if (have && int'(fr[47:16]) <= last_k) begin
          n_chk++; n_fail++;
          $display("FAIL R3 R7 ch%0d missing tag act=none exp=%0d at edge %0d",
                   c, fr[TAG_W-1:0], int'(fr[47:16]));
          if (c == 0) void'(q0.pop_front()); else void'(q1.pop_front());
        end
      end
    end
  end

  // Hold channel ch at level for n rising edges
  task automatic seg(input int ch, input bit lvl, input int n);
    pat[ch] = lvl;
    repeat (n) @(negedge clk_ofs);
  endtask

  task automatic do_reset(input logic [LEN_W-1:0] len);
    @(negedge clk_ofs);
    rst = 1'b1; use_ideal = 1'b0; pat = 2'b00;
    glitch_len = len;
    repeat (3) @(negedge clk_ofs);
    rst = 1'b0;
  endtask

  task automatic run_tests();
    // R1: reset state, checked by monitor while rst is high
    repeat (4) @(negedge clk_ofs);
    rst = 1'b0;
    // R3 R5 R6 R9: independent directed patterns, N=4
    fork
      begin // ch0: glitch high, good edge, glitch low, exact-length edge
        seg(0,0,6); seg(0,1,2); seg(0,0,1); seg(0,1,6); seg(0,0,2);
        seg(0,1,3); seg(0,0,5); seg(0,1,4); seg(0,0,8);
      end
      begin // ch1: starts high, short low, then real arm and edge
        seg(1,1,5); seg(1,0,3); seg(1,1,4); seg(1,0,4); seg(1,1,5); seg(1,0,10);
      end
    join
    // R8 R9: ch1 disabled while ch0 keeps tagging
    chan_en[1] = 1'b0;
    fork
      begin seg(0,1,6); seg(0,0,6); end
      begin seg(1,1,6); seg(1,0,6); end
    join
    chan_en[1] = 1'b1;
    seg(1,1,5); seg(1,0,8);
    // R10: zero length acts as one
    do_reset(4'd0);
    seg(0,0,2); seg(0,1,1); seg(0,0,1); seg(0,1,1); seg(0,0,6);
    // R2 R4: behavioural clocks, many beats, counter wraps
    do_reset(4'd8);
    @(negedge clk_ofs);
    use_ideal = 1'b1;
    repeat (40000) @(negedge clk_ofs);
    use_ideal = 1'b0;
    repeat (20) @(negedge clk_ofs);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk_ofs);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog act=running exp=finished");
      end
    join_any
    disable fork;
    n_chk++;
    if (q0.size() + q1.size() != 0) begin
      n_fail++;
      $display("FAIL R3 pending tags act=%0d exp=0", q0.size() + q1.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule